// File: doc/BRIEF.md
# Display Interrupt Aggregator

This block gathers the interrupt sources of a display engine into one identity register and drives two kinds of request toward the host: a level line and a one-cycle message pulse. Each display pipe has its own status register. In that register, event strobes set sticky status bits and software arms individual events through enable bits. The OR of a pipe's armed, pending status feeds a single identity bit for that pipe. That identity bit is captured on the rising edge of the OR and not on its level. Two more sources feed the identity register directly: a user-command strobe and a backlight-request strobe.

Software reaches the registers through a plain write strobe, an address and a combinational read port. The expected service order clears the pipe status first and then the identity register. The level line covers the gap that edge capture leaves: it stays high while any armed pipe status is still pending, even after the identity bit has been cleared. The message pulse fires only when the identity register goes from empty to non-empty, so a bit that lands while others are still set produces no second message.

Top module: `disp_irq_hub`

## Requirements
- R1: After reset, the identity register (address 0) reads 0. The mask register (address 1) reads all ones in all 32 bits. The enable register (address 2) reads 0. Every pipe status register reads 0. `irq_o` and `msi_o` are low.
- R2: Pipe p's status register is at address 3+p. Bits 30:16 are read/write enables, and the enable at bit n+16 arms status bit n for n = 0..14. Vblank is status bit 1 with enable bit 17. Start-of-vblank is status bit 2 with enable bit 18. Status bits 31 and 15 have no enable and never contribute to the pipe's aggregate.
- R3: Status bits 31 and 15:0 of a pipe are set by a one-cycle strobe on the matching bit of `pipe_evt`, whether or not the bit is enabled. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A strobe in the same cycle as a clearing write leaves the bit set.
- R4: Identity bit 2+p latches when pipe p's aggregate (OR of status[14:0] AND enables) rises, provided enable-register bit 2+p is 1 and mask bit 2+p is 0. While the aggregate stays high, the bit is not set again, even after software clears it.
- R5: `user_evt` latches identity bit 0 and `blc_evt` latches identity bit 1, each only when its enable bit is 1 and its mask bit is 0. Otherwise the identity bit stays 0.
- R6: Writing 1 to an identity bit at address 0 clears it and writing 0 leaves it unchanged. A source that latches in the same cycle as the clear leaves the bit set.
- R7: `msi_o` is high for exactly the one cycle in which the identity register first holds a non-zero value after having held zero. No pulse comes when a bit is added to an already non-zero identity register.
- R8: `irq_o` is high whenever the identity register is non-zero or any pipe aggregate is high. It stays high after the identity register is cleared while a pipe aggregate is still pending.
- R9: The mask and enable registers hold the value written to their low 2+NUM_PIPES bits. The upper bits of the mask read as ones and the upper bits of the enable register read as zeros.
- R10: A status bit is readable in the cycle after its strobe. The pipe's identity bit, and the message pulse if the identity register was empty, appear one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the addressed register |
| user_evt | input | 1 | User-command interrupt strobe |
| blc_evt | input | 1 | Backlight-request interrupt strobe |
| pipe_evt | input | NUM_PIPES x 32 | Per-pipe event strobes, one bit per status position |
| irq_o | output | 1 | Level interrupt line |
| msi_o | output | 1 | One-cycle message interrupt pulse |

## Verification
Two collisions can fall in one cycle: a clearing write and a new set of the same bit, both for a pipe status bit and for an identity bit. A third collision is a new identity bit arriving while the register is already non-zero. The bench provokes each one by driving the event strobe and the write in the same cycle, or by pulsing two sources in consecutive cycles. A cycle-accurate model built from the requirements judges the result: set-over-clear leaves the bit readable afterwards, and the message pulse appears only on the empty-to-non-empty step. A sweep over all mask and enable combinations checks the gating of the direct sources. A sweep over each status bit checks which bits reach the pipe aggregate.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

   localparam int unsigned REG_W     = 32;
   localparam int unsigned HALF_W    = REG_W / 2;
   // status bits with clear-on-one semantics: bit 31 and bits 15:0
   localparam logic [REG_W-1:0] STAT_BITS = 32'h8000_FFFF;
   // enables sit 16 above the status they arm; bit 31 is a status, so 15 enables
   localparam int unsigned EN_OFS    = HALF_W;
   localparam int unsigned EN_W      = HALF_W - 1;

   // identity register bit positions
   localparam int unsigned ID_USER   = 0;
   localparam int unsigned ID_BLC    = 1;
   localparam int unsigned ID_PIPE0  = 2;

   // named pipe events
   localparam int unsigned ST_VBL       = 1;
   localparam int unsigned ST_VBL_START = 2;

   // register addresses
   localparam int unsigned ADR_ID    = 0;
   localparam int unsigned ADR_MASK  = 1;
   localparam int unsigned ADR_ARM   = 2;
   localparam int unsigned ADR_PIPE0 = 3;

   typedef struct packed {
      logic             stb;
      logic [REG_W-1:0] data;
   } reg_wr_t;

endpackage

// File: rtl/disp_pipe_stat.sv
module disp_pipe_stat
   import disp_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  reg_wr_t          wr,
   input  logic [REG_W-1:0] evt,
   output logic [REG_W-1:0] rd_val,
   output logic             agg,
   output logic             agg_rise
);

   logic [REG_W-1:0] st_q;
   logic [EN_W-1:0]  en_q;
   logic             agg_prev_q;
   logic [REG_W-1:0] clr;

   assign clr = wr.stb ? (wr.data & STAT_BITS) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= '0;
         en_q       <= '0;
         agg_prev_q <= 1'b0;
      end else begin
         // a strobe outranks a same-cycle clear
         st_q       <= (st_q & ~clr) | (evt & STAT_BITS);
         agg_prev_q <= agg;
         if (wr.stb) en_q <= wr.data[EN_OFS +: EN_W];
      end
   end

   assign agg      = |(st_q[EN_W-1:0] & en_q);
   assign agg_rise = agg & ~agg_prev_q;

   always_comb begin
      rd_val                 = st_q & STAT_BITS;
      rd_val[EN_OFS +: EN_W] = en_q;
   end

endmodule

// File: rtl/disp_irq_ident.sv
module disp_irq_ident
   import disp_irq_pkg::*;
#(
   parameter int unsigned ID_W   = 4,
   parameter bit          MSI_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_id,
   input  logic            wr_mask,
   input  logic            wr_arm,
   input  logic [ID_W-1:0] wdata,
   input  logic [ID_W-1:0] src,
   output logic [ID_W-1:0] id_q,
   output logic [ID_W-1:0] mask_q,
   output logic [ID_W-1:0] arm_q,
   output logic            msi
);

   logic [ID_W-1:0] latch;
   logic [ID_W-1:0] clr;
   logic [ID_W-1:0] id_nxt;

   assign latch  = src & arm_q & ~mask_q;
   assign clr    = wr_id ? wdata : '0;
   assign id_nxt = (id_q & ~clr) | latch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q   <= '0;
         mask_q <= '1;
         arm_q  <= '0;
      end else begin
         id_q <= id_nxt;
         if (wr_mask) mask_q <= wdata;
         if (wr_arm)  arm_q  <= wdata;
      end
   end

   generate
      if (MSI_EN) begin : g_msi
         logic msi_q;
         always_ff @(posedge clk) begin
            if (!rst_n) msi_q <= 1'b0;
            else        msi_q <= (id_q == '0) && (id_nxt != '0);
         end
         assign msi = msi_q;
      end else begin : g_no_msi
         assign msi = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/disp_irq_hub.sv
module disp_irq_hub
   import disp_irq_pkg::*;
#(
   parameter int unsigned NUM_PIPES = 2,
   parameter int unsigned ADDR_W    = 3,
   parameter bit          MSI_EN    = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [REG_W-1:0]                wr_data,
   output logic [REG_W-1:0]                rd_data,
   input  logic                            user_evt,
   input  logic                            blc_evt,
   input  logic [NUM_PIPES-1:0][REG_W-1:0] pipe_evt,
   output logic                            irq_o,
   output logic                            msi_o
);

   localparam int unsigned ID_W = ID_PIPE0 + NUM_PIPES;

   generate
      if (NUM_PIPES < 1 || ID_W >= REG_W) begin : g_bad_pipes
         $error("disp_irq_hub: NUM_PIPES out of range");
      end
      if (ADR_PIPE0 + NUM_PIPES > (1 << ADDR_W)) begin : g_bad_addr
         $error("disp_irq_hub: ADDR_W too small for NUM_PIPES");
      end
   endgenerate

   logic [ID_W-1:0]      id_val;
   logic [ID_W-1:0]      mask_val;
   logic [ID_W-1:0]      arm_val;
   logic [ID_W-1:0]      src;
   logic [NUM_PIPES-1:0] pipe_agg;
   logic [NUM_PIPES-1:0] pipe_rise;
   logic [REG_W-1:0]     pipe_rd [NUM_PIPES];

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      reg_wr_t pwr;
      assign pwr.stb  = wr_en && (addr == ADDR_W'(ADR_PIPE0 + p));
      assign pwr.data = wr_data;

      disp_pipe_stat u_stat (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (pwr),
         .evt      (pipe_evt[p]),
         .rd_val   (pipe_rd[p]),
         .agg      (pipe_agg[p]),
         .agg_rise (pipe_rise[p])
      );
   end

   always_comb begin
      src                           = '0;
      src[ID_USER]                  = user_evt;
      src[ID_BLC]                   = blc_evt;
      src[ID_PIPE0 +: NUM_PIPES]    = pipe_rise;
   end

   disp_irq_ident #(
      .ID_W   (ID_W),
      .MSI_EN (MSI_EN)
   ) u_ident (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_id   (wr_en && addr == ADDR_W'(ADR_ID)),
      .wr_mask (wr_en && addr == ADDR_W'(ADR_MASK)),
      .wr_arm  (wr_en && addr == ADDR_W'(ADR_ARM)),
      .wdata   (wr_data[ID_W-1:0]),
      .src     (src),
      .id_q    (id_val),
      .mask_q  (mask_val),
      .arm_q   (arm_val),
      .msi     (msi_o)
   );

   always_comb begin
      rd_data = '0;
      if (addr == ADDR_W'(ADR_ID))
         rd_data = {{(REG_W-ID_W){1'b0}}, id_val};
      else if (addr == ADDR_W'(ADR_MASK))
         rd_data = {{(REG_W-ID_W){1'b1}}, mask_val};
      else if (addr == ADDR_W'(ADR_ARM))
         rd_data = {{(REG_W-ID_W){1'b0}}, arm_val};
      for (int p = 0; p < NUM_PIPES; p++) begin
         if (addr == ADDR_W'(ADR_PIPE0 + p)) rd_data = pipe_rd[p];
      end
   end

   assign irq_o = (|id_val) | (|pipe_agg);

endmodule

// File: rtl/disp_irq_hub_chk.sv
module disp_irq_hub_chk
   import disp_irq_pkg::*;
#(
   parameter int unsigned NUM_PIPES = 2,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned ID_W      = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    addr,
   input logic                 irq_o,
   input logic                 msi_o,
   input logic [ID_W-1:0]      id_val,
   input logic [ID_W-1:0]      mask_val,
   input logic [ID_W-1:0]      arm_val,
   input logic [NUM_PIPES-1:0] pipe_agg
);

   assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_val == '1 && arm_val == '0 && id_val == '0));

   assert_msi_empty_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msi_o |-> ($past(id_val) == '0 && id_val != '0));

   assert_id_clear_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(id_val) & ~id_val)) |-> $past(wr_en && addr == ADDR_W'(ADR_ID)));

   assert_line_covers_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (id_val != '0 || pipe_agg != '0) |-> irq_o);

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe_chk
      assert_pipe_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(id_val[ID_PIPE0+p]) |-> ($past(pipe_agg[p]) && !$past(pipe_agg[p], 2)));
   end

endmodule

bind disp_irq_hub disp_irq_hub_chk #(
   .NUM_PIPES (NUM_PIPES),
   .ADDR_W    (ADDR_W),
   .ID_W      (ID_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .irq_o    (irq_o),
   .msi_o    (msi_o),
   .id_val   (id_val),
   .mask_val (mask_val),
   .arm_val  (arm_val),
   .pipe_agg (pipe_agg)
);

// File: tb/disp_irq_hub_bench.sv
module disp_irq_hub_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 2;
   localparam int AW         = 3;
   localparam int IW         = 2 + NP;
   localparam logic [31:0] SMASK = 32'h8000_FFFF;

   logic                 clk      = 1'b0;
   logic                 rst_n    = 1'b0;
   logic                 wr_en    = 1'b0;
   logic [AW-1:0]        addr     = '0;
   logic [31:0]          wr_data  = '0;
   logic [31:0]          rd_data;
   logic                 user_evt = 1'b0;
   logic                 blc_evt  = 1'b0;
   logic [NP-1:0][31:0]  pipe_evt = '0;
   logic                 irq_o;
   logic                 msi_o;

   int n_chk = 0;
   int n_bad = 0;

   // reference state built from the requirements
   logic [31:0]   m_st   [NP];
   logic [14:0]   m_en   [NP];
   logic          m_aggp [NP];
   logic [IW-1:0] m_id, m_mask, m_arm;
   logic          m_msi;

   always #(CLK_PERIOD/2) clk = ~clk;

   disp_irq_hub #(.NUM_PIPES(NP), .ADDR_W(AW), .MSI_EN(1'b1)) u_disp_irq_hub (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .user_evt(user_evt), .blc_evt(blc_evt),
      .pipe_evt(pipe_evt), .irq_o(irq_o), .msi_o(msi_o)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic m_agg(int p);
      return |(m_st[p][14:0] & m_en[p]);
   endfunction

   function automatic logic m_irq();
      logic r = |m_id;
      for (int p = 0; p < NP; p++) r |= m_agg(p);
      return r;
   endfunction

   function automatic logic [31:0] m_read(int a);
      if (a == 0) return {{(32-IW){1'b0}}, m_id};
      if (a == 1) return {{(32-IW){1'b1}}, m_mask};
      if (a == 2) return {{(32-IW){1'b0}}, m_arm};
      return (m_st[a-3] & SMASK) | {1'b0, m_en[a-3], 16'h0};
   endfunction

   function automatic void model_reset();
      for (int p = 0; p < NP; p++) begin
         m_st[p] = '0; m_en[p] = '0; m_aggp[p] = 1'b0;
      end
      m_id = '0; m_mask = '1; m_arm = '0; m_msi = 1'b0;
   endfunction

   function automatic void model_edge();
      logic [IW-1:0] src, clr, nx;
      logic [31:0]   sc;
      src = '0;
      src[0] = user_evt;
      src[1] = blc_evt;
      for (int p = 0; p < NP; p++) src[2+p] = m_agg(p) & ~m_aggp[p];
      clr = (wr_en && addr == 0) ? wr_data[IW-1:0] : '0;
      nx = (m_id & ~clr) | (src & m_arm & ~m_mask);
      m_msi = (m_id == '0) && (nx != '0);
      for (int p = 0; p < NP; p++) m_aggp[p] = m_agg(p);
      m_id = nx;
      for (int p = 0; p < NP; p++) begin
         sc = (wr_en && addr == AW'(3+p)) ? (wr_data & SMASK) : '0;
         m_st[p] = (m_st[p] & ~sc) | (pipe_evt[p] & SMASK);
         if (wr_en && addr == AW'(3+p)) m_en[p] = wr_data[30:16];
      end
      if (wr_en && addr == 1) m_mask = wr_data[IW-1:0];
      if (wr_en && addr == 2) m_arm  = wr_data[IW-1:0];
   endfunction

   // one clock with the inputs already driven; outputs sampled at the falling edge
   task automatic cyc(string req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(req, "msi_o", 32'(msi_o), 32'(m_msi));
      check(req, "irq_o", 32'(irq_o), 32'(m_irq()));
      wr_en = 1'b0; user_evt = 1'b0; blc_evt = 1'b0; pipe_evt = '0;
   endtask

   task automatic wr(int a, logic [31:0] d, string req);
      wr_en = 1'b1; addr = AW'(a); wr_data = d;
      cyc(req);
   endtask

   task automatic rd_chk(int a, string req);
      addr = AW'(a);
      #1;
      check(req, $sformatf("reg%0d", a), rd_data, m_read(a));
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", "irq_o", 32'(irq_o), 32'h0);
      check("R1", "msi_o", 32'(msi_o), 32'h0);
      for (int a = 0; a < 5; a++) rd_chk(a, "R1");

      // R9: mask / enable register access
      wr(1, 32'h0000_0005, "R9"); rd_chk(1, "R9");
      wr(2, 32'hFFFF_FFFA, "R9"); rd_chk(2, "R9");

      // R5: every mask x enable combination for the direct sources
      for (int mk = 0; mk < 16; mk++) begin
         for (int en = 0; en < 16; en++) begin
            wr(1, 32'(mk), "R5");
            wr(2, 32'(en), "R5");
            wr(0, 32'hF, "R6");
            user_evt = 1'b1; blc_evt = 1'b1;
            cyc("R5");
            rd_chk(0, "R5");
         end
      end
      wr(0, 32'hF, "R6");
      wr(1, 32'h0, "R9");
      wr(2, 32'hF, "R9");

      // R10 / R2: vblank on pipe 0, latency of status then identity bit
      wr(3, 32'h1 << 17, "R2");
      pipe_evt[0] = 32'h1 << 1;
      cyc("R10");
      rd_chk(3, "R10");
      rd_chk(0, "R10");
      cyc("R10");
      rd_chk(0, "R4");
      // start-of-vblank on pipe 1
      wr(4, 32'h1 << 18, "R2");
      pipe_evt[1] = 32'h1 << 2;
      cyc("R2"); cyc("R2");
      rd_chk(4, "R2");
      rd_chk(0, "R2");

      // R4 / R8: clear identity while pipes still pending
      wr(0, 32'hF, "R8");
      rd_chk(0, "R4");
      pipe_evt[0] = 32'h1 << 1;
      cyc("R4"); cyc("R4");
      rd_chk(0, "R4");

      // R3: write 0 keeps status, collision keeps status, write 1 clears
      wr(3, 32'h1 << 17, "R3");
      rd_chk(3, "R3");
      wr_en = 1'b1; addr = 3; wr_data = (32'h1 << 17) | 32'h2; pipe_evt[0] = 32'h2;
      cyc("R3");
      rd_chk(3, "R3");
      wr(3, (32'h1 << 17) | 32'h2, "R3");
      rd_chk(3, "R3");
      wr(4, (32'h1 << 18) | 32'h4, "R8");
      cyc("R8");
      // re-arm after pending status cleared: new edge latches again
      pipe_evt[0] = 32'h2;
      cyc("R4"); cyc("R7");
      rd_chk(0, "R4");
      wr(0, 32'hF, "R6");

      // R7: second source onto non-empty identity gives no pulse
      user_evt = 1'b1; cyc("R7");
      blc_evt  = 1'b1; cyc("R7");
      rd_chk(0, "R7");
      wr(0, 32'hF, "R7");

      // R6: same-cycle set and clear of bit 0
      wr_en = 1'b1; addr = 0; wr_data = 32'h1; user_evt = 1'b1;
      cyc("R6");
      rd_chk(0, "R6");
      wr(0, 32'hF, "R6");

      // R3: strobes set every status bit with enables off
      wr(3, 32'h0, "R3");
      pipe_evt[0] = 32'hFFFF_FFFF;
      cyc("R3");
      rd_chk(3, "R3");
      wr(3, 32'hFFFF_FFFF & SMASK, "R3");

      // R2: enabled sweep; bits 31 and 15 never raise the aggregate
      wr(3, 32'h7FFF_0000, "R2");
      pipe_evt[0] = 32'h8000_8000;
      cyc("R2"); cyc("R2");
      rd_chk(3, "R2");
      wr(3, 32'h7FFF_0000 | SMASK, "R2");
      for (int b = 0; b < 15; b++) begin
         wr(0, 32'hF, "R2");
         pipe_evt[0] = 32'h1 << b;
         cyc("R2"); cyc("R2");
         rd_chk(0, "R2");
         wr(3, 32'h7FFF_0000 | (32'h1 << b), "R2");
      end
      cyc("R8");

      finish_run();
   end

endmodule